// File: doc/BRIEF.md
# CFAR Sliding Window Sequencer

This block is the front end of an adaptive-threshold radar detector. Detected range samples arrive one at a time and are pushed into a delay line. At its centre sits the cell under test. A guard cell on each side keeps it apart from two equal groups of reference cells. The block joins those two groups into a single N-lane reference bus for a downstream sorter, and it shows the cell under test on its own output. The guard cells never leave the block.

Once reset is released, the delay line is loaded once with L = N + G + 1 samples, with no processing enables. After that, each accepted sample starts one run of fixed length N+5 cycles: three cycles of shift, N cycles of sort, one cycle of multiply and one cycle of compare. Each phase has its own enable strobe. The downstream arithmetic returns a scaled threshold. During the compare cycle the block registers whether the cell under test is above that threshold, and it pulses a run-done strobe.

Top module: `cfar_window_seq`

## Requirements
- R1: A synchronous active-high reset clears every delay-line cell and the held sample. It drives all phase enables, run_done and det_flag to 0 and restarts the initial load.
- R2: After reset, the first L = N+G+1 samples with smp_valid high are shifted straight into the line, one per clock. No phase enable and no run_done is raised during this load, and once it ends no run starts until a valid sample arrives.
- R3: Cell k holds the sample that arrived k shifts ago (cell 0 is the newest). Reference lane i (bits i*W +: W) equals cell i for i < N/2, and equals cell i+G+1 for N/2 <= i < N. cut_cell equals cell N/2+G/2. The guard cells N/2 and N/2+G/2+1 reach no output.
- R4: A valid sample seen while idle starts a run on the next clock. en_shift is high for 3 cycles, en_sort for N cycles, en_mult for 1 cycle and en_cmp for 1 cycle, back to back: N+5 cycles in all.
- R5: The line advances by one cell, with the accepted sample entering cell 0, at the clock edge that ends the shift phase. ref_cells and cut_cell then stay unchanged through sort, multiply and compare.
- R6: At most one of en_shift, en_sort, en_mult and en_cmp is high in any cycle.
- R7: run_done is high for exactly one cycle, the cycle right after the compare cycle.
- R8: det_flag is set at the end of the compare cycle to 1 when cut_cell, taken as unsigned and zero-extended, is strictly greater than thr_in, and to 0 otherwise. It keeps its value at all other times.
- R9: smp_valid during a run is ignored. That sample is neither stored nor used to start a further run.
- R10: A valid sample offered in the run_done cycle is accepted and starts the next run with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample on smp_data is offered |
| smp_data | input | W | Detected range sample, unsigned |
| thr_in | input | TW | Scaled threshold from downstream arithmetic |
| ref_cells | output | N*W | Merged reference lanes |
| cut_cell | output | W | Cell under test |
| en_shift | output | 1 | Shift phase enable |
| en_sort | output | 1 | Sort phase enable |
| en_mult | output | 1 | Multiply phase enable |
| en_cmp | output | 1 | Compare phase enable |
| run_done | output | 1 | One-cycle end-of-run strobe |
| det_flag | output | 1 | Target decision of the latest run |

## Verification
Suppose the load counter or the phase counter holds a wrong value. The bench sees this within one run: an enable appears during the initial load, or a phase is cut short or stretched, and run_done shows up on the wrong cycle. A wrong lane merge or a misplaced tap shows up on ref_cells or cut_cell at the first sort cycle after the line moves. A stray shift caused by an ignored sample is caught in the compare cycle of the same run. A flag that is registered at the wrong time, or compared with the wrong sense, is caught at the run_done cycle. This includes the case where the cell under test equals the threshold exactly.

// File: rtl/cfar_seq_pkg.sv
package cfar_seq_pkg;
    typedef enum logic [2:0] {
        PH_FILL,
        PH_IDLE,
        PH_SHIFT,
        PH_SORT,
        PH_MULT,
        PH_CMP
    } phase_t;

    localparam int unsigned SHIFT_CYC = 3;
endpackage

// File: rtl/cfar_tap_line.sv
module cfar_tap_line #(
    parameter int unsigned W = 16,
    parameter int unsigned N = 16,
    parameter int unsigned G = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_ld,
    input  logic             shift_en,
    input  logic             shift_src,
    input  logic [W-1:0]     din,
    output logic [N*W-1:0]   ref_flat,
    output logic [W-1:0]     cut
);
    localparam int unsigned L      = N + G + 1;
    localparam int unsigned HALF   = N / 2;
    localparam int unsigned CUT_IX = HALF + G / 2;
    localparam int unsigned LAG0   = HALF + G + 1;

    typedef struct packed {
        logic [L-1:0][W-1:0] cells;
        logic [W-1:0]        hold;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_ld) begin
            st_d.hold = din;
        end
        if (shift_en) begin
            st_d.cells[0] = shift_src ? st_q.hold : din;
            for (int k = 1; k < int'(L); k++) begin
                st_d.cells[k] = st_q.cells[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // lanes 0..HALF-1 from the newer group, HALF..N-1 from the older group
    for (genvar g = 0; g < int'(HALF); g++) begin : g_merge
        assign ref_flat[g*W +: W]        = st_q.cells[g];
        assign ref_flat[(g+HALF)*W +: W] = st_q.cells[LAG0+g];
    end

    assign cut = st_q.cells[CUT_IX];

    // R5: window frozen whenever the controller does not request a shift
    p_window_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(cut) && $stable(ref_flat)));
endmodule

// File: rtl/cfar_run_ctrl.sv
module cfar_run_ctrl
    import cfar_seq_pkg::*;
#(
    parameter int unsigned N = 16,
    parameter int unsigned L = 19
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_valid,
    output phase_t phase,
    output logic   line_shift,
    output logic   shift_src,
    output logic   hold_ld,
    output logic   run_done
);
    localparam int unsigned CW = $clog2(L + N + 4);
    localparam logic [CW-1:0] FILL_LAST  = CW'(L - 1);
    localparam logic [CW-1:0] SORT_LAST  = CW'(N - 1);
    localparam logic [CW-1:0] SHIFT_LAST = CW'(SHIFT_CYC - 1);

    typedef struct packed {
        phase_t        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctl_t;

    ctl_t c_d, c_q;

    always_comb begin
        c_d        = c_q;
        c_d.done   = 1'b0;
        line_shift = 1'b0;
        shift_src  = 1'b0;
        hold_ld    = 1'b0;
        unique case (c_q.ph)
            PH_FILL: begin
                if (smp_valid) begin
                    line_shift = 1'b1;
                    if (c_q.cnt == FILL_LAST) begin
                        c_d.ph  = PH_IDLE;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + CW'(1);
                    end
                end
            end
            PH_IDLE: begin
                if (smp_valid) begin
                    hold_ld = 1'b1;
                    c_d.ph  = PH_SHIFT;
                    c_d.cnt = '0;
                end
            end
            PH_SHIFT: begin
                if (c_q.cnt == SHIFT_LAST) begin
                    line_shift = 1'b1;
                    shift_src  = 1'b1;
                    c_d.ph     = PH_SORT;
                    c_d.cnt    = '0;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            PH_SORT: begin
                if (c_q.cnt == SORT_LAST) begin
                    c_d.ph  = PH_MULT;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + CW'(1);
                end
            end
            PH_MULT: c_d.ph = PH_CMP;
            PH_CMP: begin
                c_d.ph   = PH_IDLE;
                c_d.done = 1'b1;
            end
            default: begin
                c_d.ph  = PH_FILL;
                c_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '{ph: PH_FILL, cnt: '0, done: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign phase    = c_q.ph;
    assign run_done = c_q.done;

    // checker counter: length of the latest sort phase
    logic [CW-1:0] sort_seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            sort_seen_q <= '0;
        end else if (c_q.ph == PH_SORT) begin
            sort_seen_q <= sort_seen_q + CW'(1);
        end else begin
            sort_seen_q <= '0;
        end
    end

    p_sort_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(c_q.ph == PH_SORT) |-> (sort_seen_q == CW'(N)));

    p_shift_len_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(c_q.ph == PH_SORT) |->
            ($past(c_q.ph, 1) == PH_SHIFT && $past(c_q.ph, 2) == PH_SHIFT &&
             $past(c_q.ph, 3) == PH_SHIFT));

    p_mult_order_r4: assert property (@(posedge clk) disable iff (rst)
        (c_q.ph == PH_MULT) |-> ($past(c_q.ph) == PH_SORT));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        run_done |=> !run_done);

    p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
        run_done |-> ($past(c_q.ph) == PH_CMP));
endmodule

// File: rtl/cfar_flag_unit.sv
module cfar_flag_unit #(
    parameter int unsigned W  = 16,
    parameter int unsigned TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_en,
    input  logic [W-1:0]  cut,
    input  logic [TW-1:0] thr,
    output logic          det_flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (cmp_en) begin
            flag_d = (TW'(cut) > thr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign det_flag = flag_q;

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cmp_en |=> $stable(det_flag));
endmodule

// File: rtl/cfar_window_seq.sv
module cfar_window_seq
    import cfar_seq_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned N  = 16,
    parameter int unsigned G  = 2,
    parameter int unsigned TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_data,
    input  logic [TW-1:0] thr_in,
    output logic [N*W-1:0] ref_cells,
    output logic [W-1:0]  cut_cell,
    output logic          en_shift,
    output logic          en_sort,
    output logic          en_mult,
    output logic          en_cmp,
    output logic          run_done,
    output logic          det_flag
);
    localparam int unsigned L = N + G + 1;

    phase_t phase;
    logic   line_shift, shift_src, hold_ld;

    cfar_run_ctrl #(.N(N), .L(L)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .phase      (phase),
        .line_shift (line_shift),
        .shift_src  (shift_src),
        .hold_ld    (hold_ld),
        .run_done   (run_done)
    );

    cfar_tap_line #(.W(W), .N(N), .G(G)) u_line (
        .clk       (clk),
        .rst       (rst),
        .hold_ld   (hold_ld),
        .shift_en  (line_shift),
        .shift_src (shift_src),
        .din       (smp_data),
        .ref_flat  (ref_cells),
        .cut       (cut_cell)
    );

    assign en_shift = (phase == PH_SHIFT);
    assign en_sort  = (phase == PH_SORT);
    assign en_mult  = (phase == PH_MULT);
    assign en_cmp   = (phase == PH_CMP);

    cfar_flag_unit #(.W(W), .TW(TW)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .cmp_en   (en_cmp),
        .cut      (cut_cell),
        .thr      (thr_in),
        .det_flag (det_flag)
    );

    // R9: while a run is busy the window moves only at the end of its shift phase
    p_busy_no_move_r9: assert property (@(posedge clk) disable iff (rst)
        (en_sort || en_mult || en_cmp) |=> $stable(cut_cell));

    // R8: flag changes only as a result of a compare cycle
    p_flag_after_cmp_r8: assert property (@(posedge clk) disable iff (rst)
        (det_flag != $past(det_flag)) |-> $past(en_cmp));
endmodule

// File: tb/sim_cfar_window_seq.sv
module sim_cfar_window_seq;
    localparam int unsigned W  = 16;
    localparam int unsigned N  = 16;
    localparam int unsigned G  = 2;
    localparam int unsigned TW = 32;
    localparam int unsigned L  = N + G + 1;
    localparam int unsigned HALF = N / 2;
    localparam int unsigned CUT_IX = HALF + G / 2;
    localparam int unsigned LAG0 = HALF + G + 1;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [W-1:0]  smp_data = '0;
    logic [TW-1:0] thr_in = '0;
    logic [N*W-1:0] ref_cells;
    logic [W-1:0]  cut_cell;
    logic en_shift, en_sort, en_mult, en_cmp, run_done, det_flag;

    int nchk = 0;
    int nfail = 0;
    logic [W-1:0] mdl [L];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfar_window_seq #(.W(W), .N(N), .G(G), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_in(thr_in), .ref_cells(ref_cells), .cut_cell(cut_cell),
        .en_shift(en_shift), .en_sort(en_sort), .en_mult(en_mult),
        .en_cmp(en_cmp), .run_done(run_done), .det_flag(det_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [N*W-1:0] act,
                       input logic [N*W-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic push(input logic [W-1:0] d);
        for (int k = L - 1; k > 0; k--) mdl[k] = mdl[k-1];
        mdl[0] = d;
    endtask

    function automatic logic [N*W-1:0] exp_ref();
        logic [N*W-1:0] r;
        for (int g = 0; g < int'(HALF); g++) begin
            r[g*W +: W]        = mdl[g];
            r[(g+HALF)*W +: W] = mdl[LAG0+g];
        end
        return r;
    endfunction

    function automatic logic [4:0] strobes();
        return {en_shift, en_sort, en_mult, en_cmp, run_done};
    endfunction

    task automatic check_window(input string req);
        chk(ref_cells == exp_ref(), {req, " ref lanes"}, ref_cells, exp_ref());
        chk(cut_cell == mdl[CUT_IX], {req, " cut cell"}, cut_cell, mdl[CUT_IX]);
    endtask

    // R1: reset clears everything
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < int'(L); k++) mdl[k] = '0;
        chk(strobes() == 5'b0, "R1 strobes after reset", strobes(), 0);
        chk(det_flag == 1'b0, "R1 det_flag after reset", det_flag, 0);
        chk(ref_cells == '0 && cut_cell == '0, "R1 cells cleared", ref_cells, 0);
        rst = 1'b0;
    endtask

    // R2, R3: one-time load
    task automatic t_fill(input logic [W-1:0] base);
        bit quiet = 1'b1;
        for (int i = 0; i < int'(L); i++) begin
            smp_valid = 1'b1;
            smp_data  = base + W'(i * 7);
            push(smp_data);
            @(negedge clk);
            if (strobes() != 5'b0) quiet = 1'b0;
        end
        smp_valid = 1'b0;
        chk(quiet, "R2 no enables during load", 0, 0);
        check_window("R3 after load");
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(strobes() == 5'b0, "R2 idle after load", strobes(), 0);
        check_window("R2 no extra shift");
    endtask

    // R4-R10: one run, started at the current negedge
    task automatic t_run(input logic [W-1:0] d, input int mode, input bit intrude,
                         input bit b2b);
        logic [W-1:0] ec;
        logic [4:0] es;
        bit expf;
        push(d);
        ec = mdl[CUT_IX];
        case (mode)
            0: thr_in = TW'(ec) - 1;
            1: thr_in = TW'(ec);
            default: thr_in = TW'(ec) + 1;
        endcase
        expf = (mode == 0);
        smp_valid = 1'b1;
        smp_data  = d;
        for (int c = 1; c <= int'(N) + 6; c++) begin
            @(negedge clk);
            if (c == 1) smp_valid = 1'b0;
            if (intrude && c == 2) begin
                smp_valid = 1'b1;
                smp_data  = 16'hDEAD;
            end
            if (intrude && c == int'(N) + 4) smp_valid = 1'b0;
            if (c <= 3)                es = 5'b10000;
            else if (c <= int'(N) + 3) es = 5'b01000;
            else if (c == int'(N) + 4) es = 5'b00100;
            else if (c == int'(N) + 5) es = 5'b00010;
            else                       es = 5'b00001;
            chk(strobes() == es, b2b ? "R4 R6 R7 R10 phase strobes" : "R4 R6 R7 phase strobes",
                strobes(), es);
            if (c == 3) begin
                chk(cut_cell != ec || mdl[CUT_IX] == mdl[CUT_IX+1], "R5 no move before shift end",
                    cut_cell, mdl[CUT_IX+1]);
            end
            if (c == 4) check_window("R5 window after shift");
            if (c == int'(N) + 5) check_window(intrude ? "R9 window at compare" : "R5 window at compare");
            if (c == int'(N) + 6) chk(det_flag == expf, "R8 det_flag", det_flag, expf);
        end
    endtask

    task automatic t_hold();
        logic f = det_flag;
        thr_in = f ? '1 : '0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk(det_flag == f, "R8 flag held outside compare", det_flag, f);
        chk(strobes() == 5'b0, "R9 no run without valid", strobes(), 0);
    endtask

    task automatic t_reset_mid_run();
        smp_valid = 1'b1;
        smp_data  = 16'h7777;
        @(negedge clk);
        smp_valid = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        t_reset();
        @(negedge clk);
        chk(strobes() == 5'b0, "R1 load restarts, no enables", strobes(), 0);
    endtask

    initial begin
        t_reset();
        t_fill(16'h0100);
        t_run(16'hA001, 0, 1'b0, 1'b0);
        t_run(16'hA002, 1, 1'b0, 1'b1);
        t_run(16'hA003, 2, 1'b0, 1'b1);
        t_run(16'hA004, 0, 1'b1, 1'b1);
        @(negedge clk);
        chk(strobes() == 5'b0, "R9 intruding sample not started", strobes(), 0);
        check_window("R9 window after intrusion");
        t_hold();
        t_run(16'hFFFF, 1, 1'b0, 1'b0);
        t_reset_mid_run();
        t_fill(16'h2000);
        t_run(16'h0055, 0, 1'b0, 1'b0);
        t_run(16'h0066, 2, 1'b0, 1'b1);
        summary();
    end
endmodule